// File: doc/BRIEF.md
# H-Bridge Gate Command Decoder

This block converts a pair of logic control lines into the four gate commands of one H-bridge: a high-side and a low-side switch on each of the two output legs. A mode line selects how the pair is read. With mode low, each line is a direct drive level for one leg. With mode high, one line gives the direction and the other enables the bridge.

Every change that turns a switch on passes through a break-before-make dead time. This is a per-leg count of system clock cycles in which both switches of that leg are off. A global disable line is driven by fault or sleep logic. It forces all gates off on the next clock edge. Once it is released, normal decoding resumes through the same dead-time path.

All control inputs pass through a multi-flop synchronizer before decoding. An external PWM applied to the control lines therefore reaches the gates with a fixed latency plus the dead time. A leg is high impedance when both of its gates are off.

Top module: `hbr_cmd_decoder`

## Requirements
- R1: `mode_sel` = 0 selects the direct mode of R2, and `mode_sel` = 1 selects the direction/enable mode of R3. For the same `ctl_a`, `ctl_b` values, the two modes give their own results.
- R2: Direct mode, where `ctl_a` drives output 1 and `ctl_b` drives output 2:
  - `ctl_a`,`ctl_b` = 0,0 leaves both legs off (coast).
  - 1,0 drives leg 1 high and leg 2 low.
  - 0,1 drives leg 1 low and leg 2 high.
  - 1,1 drives both legs low (brake).
- R3: Direction/enable mode, where `ctl_a` is the direction and `ctl_b` is the enable:
  - With enable 0, both legs are low whatever the direction.
  - With enable 1 and direction 0, leg 1 is high and leg 2 is low.
  - With enable 1 and direction 1, leg 1 is low and leg 2 is high.
- R4: A leg whose new request is off turns both of its gates off on the third rising edge after the input change: two synchronizer edges plus one decode edge. No dead time applies.
- R5: When a leg is asked for a switch it is not driving, both gates go off at the third edge. The new gate turns on at edge 3+`DEAD_CYC`. Every turn-on is preceded by exactly `DEAD_CYC` cycles with both gates of that leg off. This includes turn-on from the off state.
- R6: The high-side and low-side gates of one leg are never on in the same cycle.
- R7: `kill` high turns every gate off on the next rising edge and holds them off. After `kill` is released, a driven request turns its gate on at the (`DEAD_CYC`+1)-th edge after release.
- R8: If the request of a leg changes again while its dead time is counting, the count restarts from the new request.
- R9: While `rst_n` is low, all four gates are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| mode_sel | input | 1 | 0: direct mode, 1: direction/enable mode |
| ctl_a | input | 1 | Leg-1 level (direct) or direction (dir/enable) |
| ctl_b | input | 1 | Leg-2 level (direct) or enable (dir/enable) |
| kill | input | 1 | Synchronous global disable, all gates off |
| hs_on | output | 2 | High-side gate commands, bit 0 leg 1, bit 1 leg 2 |
| ls_on | output | 2 | Low-side gate commands, bit 0 leg 1, bit 1 leg 2 |

## Verification
The bench builds the decoder with `DEAD_CYC` = 3 and `SYNC_STAGES` = 2. At these values every transition settles within about ten cycles. This makes it cheap to sweep all 64 ordered pairs of the three-bit control word (mode, a, b) and to compare both legs against a computed timeline on every sample. A dead time of three also separates an off-by-one in the counter from the correct count. It leaves enough room to inject a second request change inside the window, which checks the restart behaviour. The disable path and the reset state are driven directly.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
   typedef enum logic [1:0] {
      LEG_OFF = 2'd0,
      LEG_HI  = 2'd1,
      LEG_LO  = 2'd2
   } leg_req_e;
endpackage

// File: rtl/hbr_sync.sv
module hbr_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hbr_decode.sv
module hbr_decode
   import hbr_pkg::*;
(
   input  logic     dir_mode,
   input  logic     sel_a,
   input  logic     sel_b,
   output leg_req_e req_p1,
   output leg_req_e req_p2
);
   always_comb begin
      if (dir_mode) begin
         // sel_b enables, sel_a picks the direction (R3)
         if (!sel_b) begin
            req_p1 = LEG_LO;
            req_p2 = LEG_LO;
         end else if (sel_a) begin
            req_p1 = LEG_LO;
            req_p2 = LEG_HI;
         end else begin
            req_p1 = LEG_HI;
            req_p2 = LEG_LO;
         end
      end else begin
         // one level per leg, both low means float (R2)
         unique case ({sel_a, sel_b})
            2'b00:   begin req_p1 = LEG_OFF; req_p2 = LEG_OFF; end
            2'b01:   begin req_p1 = LEG_LO;  req_p2 = LEG_HI;  end
            2'b10:   begin req_p1 = LEG_HI;  req_p2 = LEG_LO;  end
            default: begin req_p1 = LEG_LO;  req_p2 = LEG_LO;  end
         endcase
      end
   end
endmodule

// File: rtl/hbr_leg.sv
module hbr_leg
   import hbr_pkg::*;
#(
   parameter int DEAD_CYC = 5
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     kill,
   input  leg_req_e req,
   output logic     hi_on,
   output logic     lo_on
);
   localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);
   localparam logic [CW-1:0] FULL = CW'(DEAD_CYC);

   generate
      if (DEAD_CYC < 1) begin : g_bad_dead
         $error("hbr_leg: DEAD_CYC must be at least 1");
      end
   endgenerate

   logic          hi_q, lo_q;
   logic [CW-1:0] cnt_q;
   leg_req_e      tgt_q;
   leg_req_e      driven;

   assign driven = hi_q ? LEG_HI : (lo_q ? LEG_LO : LEG_OFF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= 1'b0;
         lo_q  <= 1'b0;
         cnt_q <= '0;
         tgt_q <= LEG_OFF;
      end else if (kill || req == LEG_OFF) begin
         hi_q  <= 1'b0;
         lo_q  <= 1'b0;
         cnt_q <= '0;
         tgt_q <= LEG_OFF;
      end else if (req == driven) begin
         cnt_q <= '0;
         tgt_q <= req;
      end else if (req != tgt_q) begin
         // new target: break first, restart the gap
         hi_q  <= 1'b0;
         lo_q  <= 1'b0;
         cnt_q <= '0;
         tgt_q <= req;
      end else if (cnt_q == LAST) begin
         hi_q  <= (req == LEG_HI);
         lo_q  <= (req == LEG_LO);
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign hi_on = hi_q;
   assign lo_on = lo_q;

   // checker-only count of consecutive all-off cycles, saturating
   logic [CW-1:0] gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              gap_q <= '0;
      else if (hi_q || lo_q)   gap_q <= '0;
      else if (gap_q != FULL)  gap_q <= gap_q + 1'b1;
   end

   assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_q && lo_q));

   assert_kill_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (!hi_q && !lo_q));

   assert_off_fast_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req == LEG_OFF) |=> (!hi_q && !lo_q));

   assert_dead_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(hi_q) || $rose(lo_q)) |-> (gap_q == FULL));
endmodule

// File: rtl/hbr_cmd_decoder.sv
module hbr_cmd_decoder
   import hbr_pkg::*;
#(
   parameter int DEAD_CYC    = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_sel,
   input  logic       ctl_a,
   input  logic       ctl_b,
   input  logic       kill,
   output logic [1:0] hs_on,
   output logic [1:0] ls_on
);
   localparam int NLEG   = 2;
   localparam int NCTL   = 3;

   logic [NCTL-1:0] ctl_s;
   leg_req_e        req [NLEG];

   hbr_sync #(.W(NCTL), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({mode_sel, ctl_a, ctl_b}),
      .q_o   (ctl_s)
   );

   hbr_decode u_dec (
      .dir_mode (ctl_s[2]),
      .sel_a    (ctl_s[1]),
      .sel_b    (ctl_s[0]),
      .req_p1   (req[0]),
      .req_p2   (req[1])
   );

   generate
      for (genvar g = 0; g < NLEG; g++) begin : g_leg
         hbr_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .kill  (kill),
            .req   (req[g]),
            .hi_on (hs_on[g]),
            .lo_on (ls_on[g])
         );
      end
   endgenerate

   assert_reset_off_R9: assert property (@(posedge clk)
      !rst_n |-> (hs_on == 2'b00 && ls_on == 2'b00));
endmodule

// File: tb/hbr_cmd_decoder_test.sv
module hbr_cmd_decoder_test;
   localparam int DEAD = 3;
   localparam int LAT  = 3;   // two sync edges + one leg edge
   localparam int S_OFF = 0, S_HI = 1, S_LO = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_sel = 1'b0, ctl_a = 1'b0, ctl_b = 1'b0, kill = 1'b0;
   logic [1:0] hs_on, ls_on;

   int n_checks = 0;
   int n_fail   = 0;
   int overlap_err = 0;
   bit done = 0;

   hbr_cmd_decoder #(.DEAD_CYC(DEAD), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ctl_a(ctl_a),
      .ctl_b(ctl_b), .kill(kill), .hs_on(hs_on), .ls_on(ls_on)
   );

   always #10 clk = ~clk;

   function automatic int leg_st(int g);
      if (hs_on[g] && ls_on[g]) return 3;
      if (hs_on[g]) return S_HI;
      if (ls_on[g]) return S_LO;
      return S_OFF;
   endfunction

   // spec tables of R2 and R3
   function automatic void want(input int code, output int l1, output int l2);
      bit m, a, b;
      m = code[2]; a = code[1]; b = code[0];
      if (m) begin
         if (!b)     begin l1 = S_LO; l2 = S_LO; end
         else if (a) begin l1 = S_LO; l2 = S_HI; end
         else        begin l1 = S_HI; l2 = S_LO; end
      end else begin
         case ({a, b})
            2'b00:   begin l1 = S_OFF; l2 = S_OFF; end
            2'b01:   begin l1 = S_LO;  l2 = S_HI;  end
            2'b10:   begin l1 = S_HI;  l2 = S_LO;  end
            default: begin l1 = S_LO;  l2 = S_LO;  end
         endcase
      end
   endfunction

   task automatic check(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic apply(int code);
      mode_sel = code[2]; ctl_a = code[1]; ctl_b = code[0];
   endtask

   task automatic settle();
      repeat (LAT + DEAD + 3) @(negedge clk);
   endtask

   function automatic int timeline(int o, int n, int i);
      if (n == o) return n;
      if (i < LAT) return o;
      if (n == S_OFF) return S_OFF;
      if (i < LAT + DEAD) return S_OFF;
      return n;
   endfunction

   always @(negedge clk)
      if (rst_n && ((hs_on & ls_on) != 2'b00)) overlap_err++;

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual 1 expected 0");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int e1, e2, o1, o2, x1, x2;
      // R9 reset
      repeat (3) @(negedge clk);
      check("R9 hs", int'(hs_on), 0);
      check("R9 ls", int'(ls_on), 0);
      rst_n = 1'b1;
      settle();
      check("R9 after", int'(hs_on | ls_on), 0);

      // R2 / R3 steady decode, every control word
      for (int c = 0; c < 8; c++) begin
         apply(c);
         settle();
         want(c, e1, e2);
         check(c[2] ? "R3 leg1" : "R2 leg1", leg_st(0), e1);
         check(c[2] ? "R3 leg2" : "R2 leg2", leg_st(1), e2);
      end

      // R1: same pins, two readings
      apply(3'b000); settle();
      check("R1 direct 00 coast", leg_st(0) + 4 * leg_st(1), S_OFF);
      apply(3'b100); settle();
      check("R1 dir/en 00 brake", leg_st(0) + 4 * leg_st(1), S_LO + 4 * S_LO);

      // R4 / R5: every ordered pair of control words, cycle timeline
      for (int f = 0; f < 8; f++) begin
         for (int t = 0; t < 8; t++) begin
            apply(f);
            settle();
            want(f, o1, o2);
            want(t, x1, x2);
            apply(t);
            for (int i = 1; i <= LAT + DEAD + 2; i++) begin
               @(negedge clk);
               e1 = timeline(o1, x1, i);
               e2 = timeline(o2, x2, i);
               check(x1 == S_OFF ? "R4 leg1" : (x1 == o1 ? "R1 leg1" : "R5 leg1"),
                     leg_st(0), e1);
               check(x2 == S_OFF ? "R4 leg2" : (x2 == o2 ? "R1 leg2" : "R5 leg2"),
                     leg_st(1), e2);
            end
         end
      end

      // R7 kill
      apply(3'b010); settle();
      kill = 1'b1;
      @(negedge clk);
      check("R7 off next edge", int'(hs_on | ls_on), 0);
      apply(3'b001);
      repeat (6) @(negedge clk);
      check("R7 held off", int'(hs_on | ls_on), 0);
      kill = 1'b0;
      for (int i = 1; i <= DEAD + 2; i++) begin
         @(negedge clk);
         check("R7 release leg1", leg_st(0), (i <= DEAD) ? S_OFF : S_LO);
         check("R7 release leg2", leg_st(1), (i <= DEAD) ? S_OFF : S_HI);
      end

      // R8 restart: reverse -> forward -> reverse within dead time
      apply(3'b001); settle();
      apply(3'b010);
      for (int i = 1; i <= LAT + DEAD + 6; i++) begin
         @(negedge clk);
         if (i == 2) apply(3'b001);
         e1 = (i < LAT) ? S_LO : ((i < LAT + 2 + DEAD) ? S_OFF : S_LO);
         e2 = (i < LAT) ? S_HI : ((i < LAT + 2 + DEAD) ? S_OFF : S_HI);
         check("R8 leg1", leg_st(0), e1);
         check("R8 leg2", leg_st(1), e2);
      end

      check("R6 overlap cycles", overlap_err, 0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule